// File: doc/BRIEF.md
# Configurable Microsecond Timebase

This block turns the system clock into a programmable timebase. A first divider makes a one-microsecond strobe from one of four supported input clock frequencies. A second divider stretches that strobe into a tick of 1, 4, 8 or 32 microseconds. Each tick advances a 16-bit free-running CLOCK counter and moves a 16-bit down-counting TIMER one step towards zero. When the TIMER reaches zero, a one-cycle expiry strobe is raised.

A small configuration register holds four fields: the frequency select, the rate select, an auto-clear flag and a count-enable flag. The host writes all four fields at once. A sequencer that runs a wait-for-clock instruction can turn counting on with a single request pulse. A controller start pulse clears CLOCK, but only while the auto-clear flag is set. The host can load CLOCK and TIMER directly. All pins are plain control and status pins. No data stream crosses the boundary, so there is no valid/ready handshake.

Top module: `usec_timebase`

## Requirements
- R1: After reset, the configuration is frequency select 01 (16 MHz), rate select 00, auto-clear 1 and count enable 0. CLOCK, TIMER, tick and expiry are all 0. The first tick is high in the 16th cycle after reset release, and ticks then repeat every 16 cycles.
- R2: The microsecond strobe period is 12, 16, 20 or 24 cycles for frequency select 00, 01, 10 or 11.
- R3: The tick period is the microsecond period times 1, 4, 8 or 32 for rate select 00, 01, 10 or 11. Tick is high for exactly one cycle, and only in a cycle where the microsecond strobe is also high.
- R4: While count enable is 0, CLOCK holds its value. While count enable is 1, CLOCK increments by one in the cycle after each tick, and it wraps from 0xFFFF to 0x0000.
- R5: A `wait_req` pulse sets count enable from the next cycle on. A configuration write with enable 0 clears it, unless `wait_req` is high in the same cycle.
- R6: A `start` pulse clears CLOCK to 0x0000 in the next cycle when auto-clear is 1. When auto-clear is 0, `start` leaves CLOCK unchanged.
- R7: A host CLOCK load takes effect in the next cycle. It wins over a `start` clear and over a tick increment in the same cycle.
- R8: A host TIMER load takes effect in the next cycle. TIMER decrements by one on each tick while it is non-zero, and it holds at zero.
- R9: `tmr_expired` is high for one cycle, in the cycle after a tick that takes TIMER from 1 to 0. Loading zero, or a load in the same cycle as that tick, gives no pulse.
- R10: A configuration write takes effect from the next cycle. Neither divider is reset by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write all configuration fields |
| cfg_freq | input | 2 | Input clock frequency select |
| cfg_rate | input | 2 | Tick period select |
| cfg_auto_clr | input | 1 | Clear CLOCK on start |
| cfg_cnt_en | input | 1 | CLOCK count enable |
| wait_req | input | 1 | Set count enable (wait-for-clock instruction) |
| start | input | 1 | Controller start pulse |
| clk_ld | input | 1 | Load CLOCK from host |
| clk_ld_val | input | 16 | CLOCK load value |
| tmr_ld | input | 1 | Load TIMER from host |
| tmr_ld_val | input | 16 | TIMER load value |
| clock_val | output | 16 | CLOCK counter |
| timer_val | output | 16 | TIMER counter |
| tick | output | 1 | One-cycle tick strobe |
| tmr_expired | output | 1 | One-cycle TIMER-reached-zero strobe |

## Verification
The assertions assume that every input has a known value at each clock edge after reset. They also assume that the load values are meaningful in any cycle where their load strobe is high. No handshake or pulse-width rule is placed on `start`, `wait_req` or the loads. Any of them may be held high, or may coincide with a tick. The bench drives every input to a defined level from the start of reset and changes inputs only on falling edges. It deliberately makes loads, starts and enable writes coincide, so that the priority rules are exercised.

// File: rtl/usec_timebase_pkg.sv
package usec_timebase_pkg;

  typedef struct packed {
    logic [1:0] freq;
    logic [1:0] rate;
    logic       auto_clr;
    logic       cnt_en;
  } tb_cfg_t;

  localparam tb_cfg_t CFG_RESET = '{freq: 2'b01, rate: 2'b00, auto_clr: 1'b1, cnt_en: 1'b0};

  function automatic int unsigned pick4(input logic [1:0] sel, input int unsigned a,
                                        input int unsigned b, input int unsigned c,
                                        input int unsigned d);
    case (sel)
      2'd0:    return a;
      2'd1:    return b;
      2'd2:    return c;
      default: return d;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/usec_prescale.sv
module usec_prescale #(
  parameter int unsigned BASE_DIV = 12,
  parameter int unsigned STEP_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] freq_sel,
  output logic       us_stb
);
  localparam int unsigned MAXDIV = BASE_DIV + 3 * STEP_DIV;
  localparam int unsigned CW     = $clog2(MAXDIV + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb begin
    lim    = CW'(BASE_DIV + STEP_DIV * int'(freq_sel) - 1);
    us_stb = (cnt_q >= lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (us_stb) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/usec_ratediv.sv
module usec_ratediv
  import usec_timebase_pkg::*;
#(
  parameter int unsigned RATE0 = 1,
  parameter int unsigned RATE1 = 4,
  parameter int unsigned RATE2 = 8,
  parameter int unsigned RATE3 = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       us_stb,
  output logic       tick
);
  localparam int unsigned RMAX = max4(RATE0, RATE1, RATE2, RATE3);

  generate
    if (RMAX <= 1) begin : g_pass
      logic sel_unused;
      assign sel_unused = ^rate_sel;
      assign tick = us_stb;
    end else begin : g_div
      localparam int unsigned RW = $clog2(RMAX);
      logic [RW-1:0] cnt_q;
      logic [RW-1:0] lim;

      always_comb begin
        lim  = RW'(pick4(rate_sel, RATE0, RATE1, RATE2, RATE3) - 1);
        tick = us_stb && (cnt_q >= lim);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else if (us_stb) cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/usec_counters.sv
module usec_counters #(
  parameter int unsigned CLK_W = 16,
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_en,
  input  logic             clr_req,
  input  logic             clk_ld,
  input  logic [CLK_W-1:0] clk_ld_val,
  input  logic             tmr_ld,
  input  logic [TMR_W-1:0] tmr_ld_val,
  output logic [CLK_W-1:0] clock_val,
  output logic [TMR_W-1:0] timer_val,
  output logic             tmr_expired
);
  logic [CLK_W-1:0] clk_q;
  logic [TMR_W-1:0] tmr_q;
  logic             exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               clk_q <= '0;
    else if (clk_ld)          clk_q <= clk_ld_val;
    else if (clr_req)         clk_q <= '0;
    else if (tick && cnt_en)  clk_q <= clk_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= tick && !tmr_ld && (tmr_q == TMR_W'(1));
      if (tmr_ld)                    tmr_q <= tmr_ld_val;
      else if (tick && tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
    end
  end

  assign clock_val   = clk_q;
  assign timer_val   = tmr_q;
  assign tmr_expired = exp_q;
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import usec_timebase_pkg::*;
#(
  parameter int unsigned CLK_W    = 16,
  parameter int unsigned TMR_W    = 16,
  parameter int unsigned BASE_DIV = 12,
  parameter int unsigned STEP_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_freq,
  input  logic [1:0]       cfg_rate,
  input  logic             cfg_auto_clr,
  input  logic             cfg_cnt_en,
  input  logic             wait_req,
  input  logic             start,
  input  logic             clk_ld,
  input  logic [CLK_W-1:0] clk_ld_val,
  input  logic             tmr_ld,
  input  logic [TMR_W-1:0] tmr_ld_val,
  output logic [CLK_W-1:0] clock_val,
  output logic [TMR_W-1:0] timer_val,
  output logic             tick,
  output logic             tmr_expired
);
  tb_cfg_t cfg_q;
  logic    us_stb;
  logic    en_q;
  logic    auto_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else begin
      if (cfg_wr) begin
        cfg_q.freq     <= cfg_freq;
        cfg_q.rate     <= cfg_rate;
        cfg_q.auto_clr <= cfg_auto_clr;
      end
      cfg_q.cnt_en <= (cfg_wr ? cfg_cnt_en : cfg_q.cnt_en) | wait_req;
    end
  end

  assign en_q   = cfg_q.cnt_en;
  assign auto_q = cfg_q.auto_clr;

  usec_prescale #(.BASE_DIV(BASE_DIV), .STEP_DIV(STEP_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .freq_sel(cfg_q.freq), .us_stb(us_stb)
  );

  usec_ratediv u_rate (
    .clk(clk), .rst_n(rst_n), .rate_sel(cfg_q.rate), .us_stb(us_stb), .tick(tick)
  );

  usec_counters #(.CLK_W(CLK_W), .TMR_W(TMR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_en(en_q),
    .clr_req(start && auto_q),
    .clk_ld(clk_ld), .clk_ld_val(clk_ld_val),
    .tmr_ld(tmr_ld), .tmr_ld_val(tmr_ld_val),
    .clock_val(clock_val), .timer_val(timer_val), .tmr_expired(tmr_expired)
  );
endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk #(
  parameter int unsigned CLK_W = 16,
  parameter int unsigned TMR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             us_stb,
  input logic             en_q,
  input logic             auto_q,
  input logic             start,
  input logic             wait_req,
  input logic             clk_ld,
  input logic [CLK_W-1:0] clk_ld_val,
  input logic             tmr_ld,
  input logic [CLK_W-1:0] clock_val,
  input logic [TMR_W-1:0] timer_val,
  input logic             tmr_expired
);
  AST_TICK_ON_US: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> us_stb); // R3

  AST_CLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_ld && !(start && auto_q) && !(tick && en_q)) |=> $stable(clock_val)); // R4

  AST_CLK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en_q && !clk_ld && !(start && auto_q)) |=> clock_val == CLK_W'($past(clock_val) + 1'b1)); // R4

  AST_WAIT_SETS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req |=> en_q); // R5

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && auto_q && !clk_ld) |=> clock_val == '0); // R6

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ld |=> clock_val == $past(clk_ld_val)); // R7

  AST_TMR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_val == '0 && !tmr_ld) |=> timer_val == '0); // R8

  AST_EXP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expired |-> ($past(tick) && $past(timer_val) == TMR_W'(1) && !$past(tmr_ld))); // R9

  AST_EXP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expired |=> !tmr_expired); // R9
endmodule

bind usec_timebase usec_timebase_chk #(.CLK_W(CLK_W), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .us_stb(us_stb), .en_q(en_q),
  .auto_q(auto_q), .start(start), .wait_req(wait_req), .clk_ld(clk_ld),
  .clk_ld_val(clk_ld_val), .tmr_ld(tmr_ld), .clock_val(clock_val),
  .timer_val(timer_val), .tmr_expired(tmr_expired)
);

// File: tb/sim_usec_timebase.sv
`timescale 1ns/1ps
module sim_usec_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_freq = 2'b00;
  logic [1:0]  cfg_rate = 2'b00;
  logic        cfg_auto_clr = 1'b0;
  logic        cfg_cnt_en = 1'b0;
  logic        wait_req = 1'b0;
  logic        start = 1'b0;
  logic        clk_ld = 1'b0;
  logic [15:0] clk_ld_val = '0;
  logic        tmr_ld = 1'b0;
  logic [15:0] tmr_ld_val = '0;
  logic [15:0] clock_val, timer_val;
  logic        tick, tmr_expired;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  usec_timebase u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_freq(cfg_freq), .cfg_rate(cfg_rate),
    .cfg_auto_clr(cfg_auto_clr), .cfg_cnt_en(cfg_cnt_en), .wait_req(wait_req),
    .start(start), .clk_ld(clk_ld), .clk_ld_val(clk_ld_val), .tmr_ld(tmr_ld),
    .tmr_ld_val(tmr_ld_val), .clock_val(clock_val), .timer_val(timer_val),
    .tick(tick), .tmr_expired(tmr_expired)
  );

  // ---------------- behavioural reference ----------------
  int m_us, m_rt, m_clk, m_tmr, m_f, m_r;
  bit m_a, m_e, m_exp;

  function automatic int rate_mult(int r);
    int tbl[4] = '{1, 4, 8, 32};
    return tbl[r];
  endfunction

  function automatic int us_len(int f);
    return 12 + 4 * f;
  endfunction

  function automatic bit model_tick();
    return (m_us >= us_len(m_f) - 1) && (m_rt >= rate_mult(m_r) - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_us = 0; m_rt = 0; m_clk = 0; m_tmr = 0; m_exp = 0;
      m_f = 1; m_r = 0; m_a = 1; m_e = 0;
    end else begin
      bit us, tk;
      us = (m_us >= us_len(m_f) - 1);
      tk = model_tick();
      m_exp = tk && !tmr_ld && (m_tmr == 1);
      if (clk_ld) m_clk = clk_ld_val;
      else if (start && m_a) m_clk = 0;
      else if (tk && m_e) m_clk = (m_clk + 1) % 65536;
      if (tmr_ld) m_tmr = tmr_ld_val;
      else if (tk && m_tmr != 0) m_tmr = m_tmr - 1;
      if (tk) m_rt = 0; else if (us) m_rt = m_rt + 1;
      m_us = us ? 0 : m_us + 1;
      m_e = (cfg_wr ? cfg_cnt_en : m_e) | wait_req;
      if (cfg_wr) begin m_f = cfg_freq; m_r = cfg_rate; m_a = cfg_auto_clr; end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(clock_val == 16'(m_clk), "R4", "clock_val", clock_val, m_clk);
      chk(timer_val == 16'(m_tmr), "R8", "timer_val", timer_val, m_tmr);
      chk(tick == model_tick(), "R3", "tick", tick, model_tick());
      chk(tmr_expired == m_exp, "R9", "tmr_expired", tmr_expired, m_exp);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic cfg(int f, int r, bit a, bit e);
    @(negedge clk);
    cfg_wr = 1; cfg_freq = 2'(f); cfg_rate = 2'(r); cfg_auto_clr = a; cfg_cnt_en = e;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic wait_tick();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (tick) return;
    end
  endtask

  initial begin
    int cnt, first, per;
    logic [15:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(clock_val == 0, "R1", "reset clock", clock_val, 0);
    chk(timer_val == 0, "R1", "reset timer", timer_val, 0);
    chk(tick == 0 && tmr_expired == 0, "R1", "reset strobes", {tick, tmr_expired}, 0);
    cnt = 0; first = -1;
    for (int k = 1; k <= 160; k++) begin
      @(negedge clk);
      if (tick) begin cnt++; if (first < 0) first = k; end
    end
    chk(first == 15, "R1", "first tick cycle", first, 15);
    chk(cnt == 10, "R1", "ticks in 160 cycles", cnt, 10);
    chk(clock_val == 0, "R4", "clock held while disabled", clock_val, 0);

    // R5 wait request enables counting
    @(negedge clk); wait_req = 1; @(negedge clk); wait_req = 0;
    repeat (100) @(negedge clk);
    chk(clock_val != 0, "R5", "clock counts after wait_req", clock_val, 6);

    // R2 / R3 / R10 periods for every selection
    for (int f = 0; f < 4; f++) begin
      for (int r = 0; r < 4; r++) begin
        cfg(f, r, 1, 1);
        wait_tick(); wait_tick();
        per = 0;
        for (int i = 0; i < 2000; i++) begin
          @(negedge clk); per++;
          if (tick) break;
        end
        chk(per == us_len(f) * rate_mult(r), (r == 0) ? "R2" : "R3", "tick period",
            per, us_len(f) * rate_mult(r));
      end
    end

    // R4 wrap
    cfg(0, 0, 1, 1);
    @(negedge clk); clk_ld = 1; clk_ld_val = 16'hFFFE; @(negedge clk); clk_ld = 0;
    chk(clock_val == 16'hFFFE, "R7", "clock load", clock_val, 16'hFFFE);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (clock_val == 16'h0000) begin cnt = 1; break; end
    end
    chk(cnt == 1, "R4", "wrap to zero", cnt, 1);

    // R6 start with auto-clear set
    repeat (40) @(negedge clk);
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    chk(clock_val == 0, "R6", "start clears", clock_val, 0);
    // R6 start with auto-clear off, counting off
    cfg(0, 0, 0, 0);
    @(negedge clk); clk_ld = 1; clk_ld_val = 16'h1234; @(negedge clk); clk_ld = 0;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    chk(clock_val == 16'h1234, "R6", "start ignored", clock_val, 16'h1234);
    repeat (60) @(negedge clk);
    chk(clock_val == 16'h1234, "R4", "held with enable 0", clock_val, 16'h1234);
    // R7 load wins over start clear
    cfg(0, 0, 1, 0);
    @(negedge clk); clk_ld = 1; clk_ld_val = 16'hABCD; start = 1;
    @(negedge clk); clk_ld = 0; start = 0;
    chk(clock_val == 16'hABCD, "R7", "load beats start", clock_val, 16'hABCD);

    // R5 disable write coinciding with wait request
    @(negedge clk); cfg_wr = 1; cfg_cnt_en = 0; cfg_freq = 0; cfg_rate = 0; cfg_auto_clr = 1;
    wait_req = 1;
    @(negedge clk); cfg_wr = 0; wait_req = 0;
    snap = clock_val;
    repeat (30) @(negedge clk);
    chk(clock_val != snap, "R5", "wait_req beats disable", clock_val, snap + 2);

    // R8 / R9 timer
    @(negedge clk); tmr_ld = 1; tmr_ld_val = 16'd3; @(negedge clk); tmr_ld = 0;
    chk(timer_val == 3, "R8", "timer load", timer_val, 3);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (tmr_expired) cnt++; end
    chk(cnt == 1, "R9", "single expiry", cnt, 1);
    chk(timer_val == 0, "R8", "timer holds at zero", timer_val, 0);
    @(negedge clk); tmr_ld = 1; tmr_ld_val = 16'd0; @(negedge clk); tmr_ld = 0;
    cnt = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (tmr_expired) cnt++; end
    chk(cnt == 0, "R9", "zero load no expiry", cnt, 0);

    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule